// File: doc/BRIEF.md
# Period-Locked VCO Pulse Averaging Sampler

This block gives one average reading of a converter's output voltage per switching period. A voltage-to-frequency converter turns the output voltage into a pulse train, and a front end brings that train into the clock domain as a single-cycle strobe per pulse. The block counts those strobes in one counter. The output voltage is almost flat across a period, so one window per period is enough. The count accumulated over a whole period is proportional to the mean voltage over that period.

The counting window does not come from a free-running timebase. It is tied to the period-boundary event, which marks the end of the PWM triggering pulse. On that event the running total is copied into an output register for the voltage controller, and the counter starts again from zero in the same cycle. At full scale the VCO gives about 5600 pulses per period (140 MHz against a 25 kHz switching rate), so a downstream stage can scale the word to volts by multiplying by 1/5600.

A two-state controller decides whether a boundary publishes a value. In PRIME, the state entered from reset, the window in progress began at an arbitrary moment. The transition PRIME_TO_RUN, taken on the first boundary, discards that partial count. In RUN every window is complete. The transition RUN_TO_RUN, taken on each later boundary, publishes the count. Between boundaries both states stay where they are (PRIME_HOLD, RUN_HOLD).

Top module: `pvs_sampler`

## Requirements
- R1: On a boundary cycle in RUN state, the clock edge loads `sample_count` with the number of pulses counted since the previous boundary, and `sample_valid` is 1 during the cycle after that edge.
- R2: A boundary restarts the window from zero. A pulse present in the boundary cycle is the first count of the new window, not the last of the old one.
- R3: The window count is 16 bits wide and stops at 65535 rather than wrapping, so the captured value is 65535 when more pulses arrived.
- R4: `sample_valid` is 1 only in the cycle after a boundary, and `sample_count` does not change except on a capture.
- R5: The first boundary after reset (PRIME_TO_RUN) leaves `sample_valid` at 0 and `sample_count` unchanged.
- R6: While reset (`rst_n` = 0) is applied, and after it is released, `sample_count` is 0 and `sample_valid` is 0 until the first capture.
- R7: A full-scale window of 5600 pulses, one per cycle, is captured as exactly 5600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_pulse | input | 1 | One-cycle strobe per VCO output pulse |
| period_end | input | 1 | One-cycle strobe at the end of the PWM triggering pulse |
| sample_count | output | 16 | Pulse count of the last complete period |
| sample_valid | output | 1 | High for one cycle when a new count is captured |

## Verification
A VCO pulse and a period boundary can land in the same cycle. The design must then close the old window without that pulse and open the new one with a count of 1. The bench provokes this with directed cases: boundaries on consecutive cycles, both with and without pulses. Random pulse densities and random window lengths also make the overlap happen many times. A cycle-level bench model assigns the coincident pulse to the new window, and every captured word is compared against that model.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
    // Two window states: the first window after reset is partial
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } pvs_state_t;

    localparam int unsigned PVS_CNT_W = 16;
endpackage

// File: rtl/pvs_window_fsm.sv
module pvs_window_fsm
    import pvs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    output logic capture_en
);
    pvs_state_t state_q, state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (boundary) state_d = ST_RUN;   // PRIME_TO_RUN
            ST_RUN:   state_d = ST_RUN;                  // RUN_TO_RUN / RUN_HOLD
            default:  state_d = ST_PRIME;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        capture_en = 1'b0;
        unique case (state_q)
            ST_PRIME: capture_en = 1'b0;          // partial window discarded
            ST_RUN:   capture_en = boundary;
            default:  capture_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pvs_pulse_counter.sv
module pvs_pulse_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pulse,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            // coincident pulse opens the new window
            count <= {{(CNT_W-1){1'b0}}, pulse};
        end else if (pulse && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pvs_capture_reg.sv
module pvs_capture_reg #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value_in,
    output logic [CNT_W-1:0] value_out,
    output logic             strobe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_out <= '0;
            strobe    <= 1'b0;
        end else begin
            strobe <= load;
            if (load) value_out <= value_in;
        end
    end
endmodule

// File: rtl/pvs_sampler.sv
module pvs_sampler
    import pvs_pkg::*;
#(
    parameter int unsigned CNT_W = PVS_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vco_pulse,
    input  logic             period_end,
    output logic [CNT_W-1:0] sample_count,
    output logic             sample_valid
);
    logic [CNT_W-1:0] win_count;
    logic             capture_en;

    pvs_window_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (period_end),
        .capture_en (capture_en)
    );

    pvs_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (period_end),
        .pulse   (vco_pulse),
        .count   (win_count)
    );

    pvs_capture_reg #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (capture_en),
        .value_in  (win_count),
        .value_out (sample_count),
        .strobe    (sample_valid)
    );
endmodule

// File: rtl/pvs_sampler_chk.sv
module pvs_sampler_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vco_pulse,
    input logic             period_end,
    input logic [CNT_W-1:0] win_count,
    input logic [CNT_W-1:0] sample_count,
    input logic             sample_valid
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_q <= 1'b0;
        else if (period_end) seen_q <= 1'b1;
    end

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && seen_q) |=> (sample_valid && sample_count == $past(win_count))); // R1
    AST_RESTART_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (win_count == {{(CNT_W-1){1'b0}}, $past(vco_pulse)})); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_count == CMAX && !period_end) |=> (win_count == CMAX)); // R3
    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> (!sample_valid && $stable(sample_count))); // R4
    AST_FIRST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !seen_q) |=> (!sample_valid && $stable(sample_count))); // R5
endmodule

bind pvs_sampler pvs_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vco_pulse    (vco_pulse),
    .period_end   (period_end),
    .win_count    (win_count),
    .sample_count (sample_count),
    .sample_valid (sample_valid)
);

// File: tb/test_pvs_sampler.sv
`timescale 1ns/1ps
module test_pvs_sampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_pulse = 1'b0;
    logic        period_end = 1'b0;
    logic [15:0] sample_count;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    int m_cnt = 0;
    bit m_seen = 1'b0;
    int e_sample = 0;
    bit e_valid = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pvs_sampler i_pvs_sampler (
        .clk(clk), .rst_n(rst_n), .vco_pulse(vco_pulse), .period_end(period_end),
        .sample_count(sample_count), .sample_valid(sample_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int next_cnt(int c, bit p, bit b);
        if (b) return p ? 1 : 0;
        if (p && c < 65535) return c + 1;
        return c;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(bit p, bit b, string tag);
        vco_pulse  = p;
        period_end = b;
        @(posedge clk);
        if (b) begin
            e_valid = m_seen;
            if (m_seen) e_sample = m_cnt;
            m_seen = 1'b1;
        end else begin
            e_valid = 1'b0;
        end
        m_cnt = next_cnt(m_cnt, p, b);
        @(negedge clk);
        check({tag, " valid"}, int'(sample_valid), int'(e_valid));
        check({tag, " count"}, int'(sample_count), e_sample);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        repeat (3) @(negedge clk);
        check("R6 reset count", int'(sample_count), 0);
        check("R6 reset valid", int'(sample_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after reset valid", int'(sample_valid), 0);

        // R5: first boundary discards partial window
        repeat (7) step(1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, "R5 first boundary");
        // R1: complete window of 9 pulses, R2 coincident pulse
        repeat (9) step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R2 coincident");
        repeat (4) step(1'b0, 1'b0, "R4 hold");
        step(1'b0, 1'b1, "R2 capture 1");
        // back-to-back boundaries
        step(1'b0, 1'b1, "R2 empty window");
        step(1'b1, 1'b1, "R2 b2b pulse");
        step(1'b1, 1'b1, "R2 b2b pulse2");
        // R7: full scale
        repeat (5599) step(1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, "R7 full scale");
        check("R7 full scale value", int'(sample_count), 5600);
        // R3: saturation
        repeat (70000) step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R3 saturate");
        check("R3 saturated value", int'(sample_count), 65535);
        // random windows and densities
        for (int w = 0; w < 40; w++) begin
            int len  = 20 + ($urandom % 800);
            int dens = $urandom % 101;
            for (int k = 0; k < len; k++)
                step(($urandom % 100) < dens, 1'b0, "R1 random");
            step(($urandom % 2) == 1, 1'b1, "R1 random boundary");
        end
        // R6: reset mid-window clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_seen = 1'b0; e_sample = 0; e_valid = 1'b0;
        check("R6 re-reset count", int'(sample_count), 0);
        step(1'b1, 1'b1, "R5 after re-reset");
        step(1'b0, 1'b1, "R1 single");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule